// File: doc/BRIEF.md
# Reflex Maturity Promotion Tracker

This block does the numeric bookkeeping for a single learned reflex. Each time the reflex fires, an outcome strobe reports whether the firing succeeded. The block keeps a confidence weight in unsigned Q0.16 fixed point, where full scale stands for 1.0. A success moves the weight up by a configurable step and a failure moves it down by the same step. The weight clamps at both ends rather than wrapping. A separate saturating counter records how many fires succeeded.

When the weight is strictly above the high threshold and the success count has reached the required minimum, a controller moves from the `ST_LEARN` state to the `ST_READY` state. In `ST_READY` the block raises a sticky promotion-ready flag, which tells the rest of the system that the reflex can move into dedicated logic. The controller has two transitions:
- `QUALIFY` takes `ST_LEARN` to `ST_READY`.
- `RESTART` takes any state back to `ST_LEARN` on reset or on the synchronous clear.

The weight keeps learning after promotion, and the flag stays set while it does.

Top module: `reflex_maturity_tracker`

## Requirements
- R1: After reset, and one cycle after `clr_i` is sampled high, `weight_o` is 6554 (0.1), `succ_cnt_o` is 0 and `promote_o` is 0. The clear takes priority over a fire in the same cycle.
- R2: A fire with `fire_ok_i`=1 raises `weight_o` by STEP (default 64), visible one cycle later. The weight saturates at 65535.
- R3: A fire with `fire_ok_i`=0 lowers `weight_o` by STEP, visible one cycle later. The weight saturates at 0.
- R4: Each successful fire increments `succ_cnt_o` by one. A failed fire leaves it unchanged. The counter saturates at 65535.
- R5: In a cycle with no fire and no clear, the weight and the counter hold their values.
- R6: `promote_o` rises one cycle after the registered weight is above 58982 (0.9) and the registered count is at least 1000. Either condition alone leaves `promote_o` low.
- R7: Once set, `promote_o` stays high whatever the weight does, until reset or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear back to the initial state |
| fire_i | input | 1 | Fire-outcome strobe, one event per cycle it is high |
| fire_ok_i | input | 1 | Outcome of the fire: 1 success, 0 failure |
| weight_o | output | 16 | Confidence weight, unsigned Q0.16 |
| succ_cnt_o | output | 16 | Saturating count of successful fires |
| promote_o | output | 1 | Sticky promotion-ready flag |

## Verification
A short table of mixed fires, idle cycles and a clear checks the single-step arithmetic and the priority of the clear. Alternating success and failure 1000 times brings the count to its minimum while the weight stays low, which shows that count alone does not promote. A run of successes then pushes the weight over the threshold and pins the one-cycle flag latency. A second run saturates the weight long before the count is reached, which shows that weight alone does not promote. Long runs of failures and of successes exercise both weight clamps, flag stickiness and counter saturation.

// File: rtl/reflex_pkg.sv
package reflex_pkg;
    typedef enum logic {
        ST_LEARN = 1'b0,
        ST_READY = 1'b1
    } mat_state_t;
endpackage

// File: rtl/weight_accum.sv
module weight_accum #(
    parameter int          W_W  = 16,
    parameter int          STEP = 64,
    parameter logic [15:0] INIT = 16'd6554
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           fire_i,
    input  logic           fire_ok_i,
    output logic [W_W-1:0] weight_o
);
    localparam logic [W_W-1:0] W_MAX  = {W_W{1'b1}};
    localparam logic [W_W-1:0] W_STEP = W_W'(STEP);
    localparam logic [W_W-1:0] W_INIT = W_W'(INIT);

    logic [W_W-1:0] w_q, w_d;

    always_comb begin
        w_d = w_q;
        if (clr_i)
            w_d = W_INIT;
        else if (fire_i && fire_ok_i)
            w_d = (w_q > W_MAX - W_STEP) ? W_MAX : w_q + W_STEP;
        else if (fire_i)
            w_d = (w_q < W_STEP) ? '0 : w_q - W_STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= W_INIT;
        else        w_q <= w_d;
    end

    assign weight_o = w_q;
endmodule

// File: rtl/success_counter.sv
module success_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fire_i,
    input  logic             fire_ok_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] c_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '0;
        else if (clr_i)
            c_q <= '0;
        else if (fire_i && fire_ok_i && c_q != C_MAX)
            c_q <= c_q + 1'b1;
    end

    assign cnt_o = c_q;
endmodule

// File: rtl/promo_fsm.sv
module promo_fsm
    import reflex_pkg::*;
#(
    parameter int          W_W      = 16,
    parameter int          CNT_W    = 16,
    parameter logic [15:0] HI_THR   = 16'd58982,
    parameter int          MIN_SUCC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [W_W-1:0]   weight_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             promote_o
);
    localparam logic [W_W-1:0]   THR_W = W_W'(HI_THR);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_SUCC);

    mat_state_t state_q, state_d;
    logic       qualify;

    assign qualify = (weight_i > THR_W) && (cnt_i >= MIN_C);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEARN: if (qualify) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_LEARN;
        endcase
        if (clr_i) state_d = ST_LEARN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEARN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_READY: promote_o = 1'b1;
            default:  promote_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/reflex_maturity_tracker.sv
module reflex_maturity_tracker #(
    parameter int          W_W      = 16,
    parameter int          CNT_W    = 16,
    parameter int          STEP     = 64,
    parameter logic [15:0] INIT     = 16'd6554,
    parameter logic [15:0] HI_THR   = 16'd58982,
    parameter int          MIN_SUCC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fire_i,
    input  logic             fire_ok_i,
    output logic [W_W-1:0]   weight_o,
    output logic [CNT_W-1:0] succ_cnt_o,
    output logic             promote_o
);
    weight_accum #(.W_W(W_W), .STEP(STEP), .INIT(INIT)) u_weight (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .fire_i(fire_i),
        .fire_ok_i(fire_ok_i), .weight_o(weight_o)
    );

    success_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .fire_i(fire_i),
        .fire_ok_i(fire_ok_i), .cnt_o(succ_cnt_o)
    );

    promo_fsm #(.W_W(W_W), .CNT_W(CNT_W), .HI_THR(HI_THR), .MIN_SUCC(MIN_SUCC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .weight_i(weight_o),
        .cnt_i(succ_cnt_o), .promote_o(promote_o)
    );
endmodule

// File: rtl/reflex_maturity_checker.sv
module reflex_maturity_checker #(
    parameter int          W_W      = 16,
    parameter int          CNT_W    = 16,
    parameter int          STEP     = 64,
    parameter logic [15:0] INIT     = 16'd6554,
    parameter logic [15:0] HI_THR   = 16'd58982,
    parameter int          MIN_SUCC = 1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             fire_i,
    input logic             fire_ok_i,
    input logic [W_W-1:0]   weight_o,
    input logic [CNT_W-1:0] succ_cnt_o,
    input logic             promote_o
);
    localparam logic [W_W-1:0]   W_MAX = {W_W{1'b1}};
    localparam logic [W_W-1:0]   W_STP = W_W'(STEP);
    localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};

    a_r1_clear_init: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (weight_o == W_W'(INIT) && succ_cnt_o == '0 && !promote_o));

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && fire_ok_i && !clr_i && weight_o <= W_MAX - W_STP)
        |=> weight_o == $past(weight_o) + W_STP);

    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !fire_ok_i && !clr_i && weight_o < W_STP) |=> weight_o == '0);

    a_r4_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && fire_ok_i && !clr_i && succ_cnt_o == C_MAX) |=> succ_cnt_o == C_MAX);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && !clr_i) |=> ($stable(weight_o) && $stable(succ_cnt_o)));

    a_r6_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(promote_o) |-> ($past(weight_o) > W_W'(HI_THR) &&
                              $past(succ_cnt_o) >= CNT_W'(MIN_SUCC)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (promote_o && !clr_i) |=> promote_o);
endmodule

bind reflex_maturity_tracker reflex_maturity_checker #(
    .W_W(W_W), .CNT_W(CNT_W), .STEP(STEP), .INIT(INIT),
    .HI_THR(HI_THR), .MIN_SUCC(MIN_SUCC)
) u_checker (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .fire_i(fire_i),
    .fire_ok_i(fire_ok_i), .weight_o(weight_o), .succ_cnt_o(succ_cnt_o),
    .promote_o(promote_o)
);

// File: tb/reflex_maturity_tracker_bench.sv
module reflex_maturity_tracker_bench;
    localparam int STEP = 64;
    localparam int INIT = 6554;
    localparam int THR  = 58982;
    localparam int MINS = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        fire_i = 1'b0;
    logic        fire_ok_i = 1'b0;
    logic [15:0] weight_o;
    logic [15:0] succ_cnt_o;
    logic        promote_o;

    int errors = 0;
    int checks = 0;
    int exp_w  = INIT;
    int exp_c  = 0;

    always #10 clk = ~clk;

    reflex_maturity_tracker u_reflex_maturity_tracker (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .fire_i(fire_i),
        .fire_ok_i(fire_ok_i), .weight_o(weight_o), .succ_cnt_o(succ_cnt_o),
        .promote_o(promote_o)
    );

    // [34] fire, [33] success, [32] clear, [31:16] weight, [15:0] count
    localparam logic [34:0] VEC [0:7] = '{
        {1'b1, 1'b1, 1'b0, 16'd6618, 16'd1},
        {1'b1, 1'b0, 1'b0, 16'd6554, 16'd1},
        {1'b0, 1'b0, 1'b0, 16'd6554, 16'd1},
        {1'b1, 1'b1, 1'b0, 16'd6618, 16'd2},
        {1'b1, 1'b1, 1'b0, 16'd6682, 16'd3},
        {1'b1, 1'b0, 1'b0, 16'd6618, 16'd3},
        {1'b1, 1'b1, 1'b1, 16'd6554, 16'd0},
        {1'b1, 1'b1, 1'b0, 16'd6618, 16'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input logic ok);
        if (ok) begin
            exp_w = (exp_w + STEP > 65535) ? 65535 : exp_w + STEP;
            exp_c = (exp_c == 65535) ? 65535 : exp_c + 1;
        end else begin
            exp_w = (exp_w < STEP) ? 0 : exp_w - STEP;
        end
    endtask

    task automatic pulse(input logic ok);
        @(negedge clk);
        fire_i = 1'b1; fire_ok_i = ok;
        @(negedge clk);
        fire_i = 1'b0;
        model(ok);
    endtask

    task automatic burst(input logic ok, input int n);
        @(negedge clk);
        fire_i = 1'b1; fire_ok_i = ok;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model(ok);
        end
        fire_i = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        exp_w = INIT; exp_c = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset weight", weight_o, INIT);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", succ_cnt_o, 0);
        chk("R1 reset flag", promote_o, 0);

        // table walk: single steps, idle hold, clear priority
        foreach (VEC[i]) begin
            @(negedge clk);
            fire_i = VEC[i][34]; fire_ok_i = VEC[i][33]; clr_i = VEC[i][32];
            @(negedge clk);
            fire_i = 1'b0; clr_i = 1'b0;
            chk($sformatf("R2/R3/R5/R1 vec%0d weight", i), weight_o, int'(VEC[i][31:16]));
            chk($sformatf("R4 vec%0d count", i), succ_cnt_o, int'(VEC[i][15:0]));
        end

        // R6: count reaches minimum while weight stays low
        do_clear();
        for (int i = 0; i < MINS; i++) begin
            pulse(1'b1);
            pulse(1'b0);
        end
        chk("R4 alternating count", succ_cnt_o, MINS);
        chk("R3 alternating weight", weight_o, INIT);
        @(negedge clk);
        chk("R6 count alone no flag", promote_o, 0);

        while (exp_w <= THR) pulse(1'b1);
        chk("R2 weight crossed", weight_o, exp_w);
        chk("R6 flag not yet", promote_o, 0);
        @(negedge clk);
        chk("R6 flag one cycle later", promote_o, 1);

        // R7 sticky while weight drains to floor
        burst(1'b0, 1000);
        chk("R3 weight floor", weight_o, 0);
        chk("R4 failures keep count", succ_cnt_o, exp_c);
        chk("R7 flag sticky", promote_o, 1);

        do_clear();
        chk("R1 clear flag", promote_o, 0);
        chk("R1 clear weight", weight_o, INIT);

        // R6: weight alone saturates, flag waits for count
        burst(1'b1, 950);
        chk("R2 weight ceiling", weight_o, 65535);
        burst(1'b1, 49);
        @(negedge clk);
        chk("R6 weight alone no flag", promote_o, 0);
        pulse(1'b1);
        chk("R4 count at minimum", succ_cnt_o, MINS);
        chk("R6 flag not yet on count", promote_o, 0);
        @(negedge clk);
        chk("R6 flag after count", promote_o, 1);

        // R4 counter saturation
        do_clear();
        burst(1'b1, 65540);
        chk("R4 count saturated", succ_cnt_o, 65535);
        chk("R2 weight held at ceiling", weight_o, 65535);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset weight", weight_o, INIT);
        chk("R1 async reset count", succ_cnt_o, 0);
        chk("R1 async reset flag", promote_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule